// File: doc/BRIEF.md
# Multiple-Word Register Load Sequencer

This block carries out a single load of several consecutive words into the upper part of a general-purpose register file. It takes a starting register number, a base-register field and the value of that base register, a 16-bit signed displacement and an endianness mode bit. From these it computes a starting address and reads one 32-bit word per target register. Each returned word is written into the next register, beginning at the starting register and ending at the highest register. Every written register holds the word in its low 32 bits and zeros in its upper bits.

The memory side uses a one-cycle request pulse with an address and a later acknowledge that carries the read data. Only one read is outstanding at a time. The register side is a single write port that is active for one cycle per word. Before any read is issued, the sequencer checks the operation. If the machine is in little-endian mode, or if the base register falls inside the range of registers that would be overwritten, no transfer takes place, and the matching outcome flag is shown together with the completion pulse.

Top module: `lmw_seq`

## Requirements
- R1: After reset the sequencer is idle. busy_o, mem_req_o, rf_we_o, done_o, invalid_o and align_err_o are all low until a start is accepted.
- R2: The first read address is the base plus the displacement sign-extended from bit 15 to XLEN bits. The base is zero when base_idx_i is 0, and base_val_i otherwise. All of these are sampled in the cycle the start is accepted.
- R3: A valid operation makes exactly NREGS minus first_reg_i register writes. The registers are written in increasing order, from first_reg_i up to NREGS-1 (31 by default), and the last write is to register NREGS-1.
- R4: Each read after the first is at the previous read address plus 4. The sum wraps modulo 2^XLEN.
- R5: Each register write carries the acknowledged read word in bits 31:0 and zeros in all higher bits. It is issued in the same cycle as mem_ack_i while the sequencer waits for data.
- R6: mem_req_o is a one-cycle pulse that is asserted only while busy. No new request is made until the previous one has been acknowledged.
- R7: The operation is invalid when base_idx_i is greater than or equal to first_reg_i. A base field of 0 is inside the range only when first_reg_i is 0. An invalid operation issues no read and no write, and it shows invalid_o high in the cycle of done_o.
- R8: When le_mode_i is 1 at the start, the operation issues no read and no write, and it shows align_err_o high in the cycle of done_o. When both faults apply, both flags are raised.
- R9: done_o is a one-cycle pulse. It comes after the last register write of a valid operation, or directly after the check of a faulting one. busy_o is high from the cycle after the start until the done cycle, and low in the cycle after it.
- R10: A start_i pulse that arrives while the sequencer is busy is ignored. The running operation completes with its original registers and addresses, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| first_reg_i | input | IDX_W (5) | First target register number |
| base_idx_i | input | IDX_W (5) | Base-register field; 0 selects a zero base |
| base_val_i | input | XLEN (64) | Contents of the base register |
| disp_i | input | DISP_W (16) | Signed displacement |
| le_mode_i | input | 1 | 1 = little-endian mode (operation refused) |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | XLEN (64) | Read address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | WORD_W (32) | Read data |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | IDX_W (5) | Register write index |
| rf_wdata_o | output | XLEN (64) | Register write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| invalid_o | output | 1 | Invalid-form outcome, valid with done_o |
| align_err_o | output | 1 | Alignment-error outcome, valid with done_o |

## Verification
Some rules are checked by assertions on every cycle. These are the one-cycle shape of requests and of the completion pulse, and that requests occur only while busy. The assertions also check the +4 address step between consecutive requests, the +1 register step between consecutive writes, the zero-extension of the write data, that an operation flagged with a fault made no write, and that a clean completion ended on the highest register. Some results depend on values chosen at the start, and only the bench's scenarios can show them. These are the exact starting address built from the zero-or-base selection and the sign-extended displacement, the total word count for every starting register, and wrap-around at the top of the address space. The rejection of a second start while busy is also shown by the bench scenarios.

// File: rtl/lmw_seq_pkg.sv
package lmw_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_REQ   = 3'd2,
      ST_WAIT  = 3'd3,
      ST_DONE  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/lmw_seq_form_check.sv
module lmw_seq_form_check #(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] first_q_i,
   input  logic [IDX_W-1:0] base_idx_q_i,
   input  logic             le_q_i,
   output logic             range_hit_o,
   output logic             align_fault_o
);

   // Targets run from first_q_i to the top register; the base field is in
   // that range when it is at or above the first target.
   always_comb begin
      range_hit_o   = (base_idx_q_i >= first_q_i);
      align_fault_o = le_q_i;
   end

endmodule

// File: rtl/lmw_seq_addr_gen.sv
module lmw_seq_addr_gen #(
   parameter int XLEN   = 64,
   parameter int DISP_W = 16,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              base_zero_i,
   input  logic [XLEN-1:0]   base_val_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [XLEN-1:0]   addr_o
);

   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   logic [XLEN-1:0] disp_ext;
   logic [XLEN-1:0] base_sel;
   logic [XLEN-1:0] addr_q;

   generate
      if (DISP_W == XLEN) begin : g_disp_full
         assign disp_ext = disp_i;
      end else begin : g_disp_sext
         assign disp_ext = {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};
      end
   endgenerate

   assign base_sel = base_zero_i ? '0 : base_val_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load_i) begin
         addr_q <= base_sel + disp_ext;
      end else if (step_i) begin
         addr_q <= addr_q + STEP_V;
      end
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/lmw_seq_ctrl.sv
module lmw_seq_ctrl
   import lmw_seq_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] first_reg_i,
   input  logic [IDX_W-1:0] base_idx_i,
   input  logic             le_mode_i,
   input  logic             range_hit_i,
   input  logic             align_fault_i,
   input  logic             mem_ack_i,
   output logic             accept_o,
   output logic             step_o,
   output seq_state_e       state_o,
   output logic [IDX_W-1:0] cur_reg_o,
   output logic [IDX_W-1:0] first_q_o,
   output logic [IDX_W-1:0] base_idx_q_o,
   output logic             le_q_o,
   output logic             inv_q_o,
   output logic             align_q_o
);

   localparam logic [IDX_W-1:0] LAST_REG = '1;

   seq_state_e       state_q, state_d;
   logic [IDX_W-1:0] cur_q;
   logic [IDX_W-1:0] first_q;
   logic [IDX_W-1:0] bidx_q;
   logic             le_q;
   logic             inv_q;
   logic             aln_q;
   logic             word_ack;
   logic             fault;

   assign accept_o = (state_q == ST_IDLE) && start_i;
   assign word_ack = (state_q == ST_WAIT) && mem_ack_i;
   assign step_o   = word_ack && (cur_q != LAST_REG);
   assign fault    = range_hit_i || align_fault_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start_i) state_d = ST_CHECK;
         ST_CHECK: state_d = fault ? ST_DONE : ST_REQ;
         ST_REQ:   state_d = ST_WAIT;
         ST_WAIT:  if (mem_ack_i) state_d = (cur_q == LAST_REG) ? ST_DONE : ST_REQ;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         first_q <= '0;
         bidx_q  <= '0;
         le_q    <= 1'b0;
         inv_q   <= 1'b0;
         aln_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept_o) begin
            cur_q   <= first_reg_i;
            first_q <= first_reg_i;
            bidx_q  <= base_idx_i;
            le_q    <= le_mode_i;
            inv_q   <= 1'b0;
            aln_q   <= 1'b0;
         end else if (state_q == ST_CHECK) begin
            inv_q <= range_hit_i;
            aln_q <= align_fault_i;
         end else if (step_o) begin
            cur_q <= cur_q + 1'b1;
         end
      end
   end

   assign state_o      = state_q;
   assign cur_reg_o    = cur_q;
   assign first_q_o    = first_q;
   assign base_idx_q_o = bidx_q;
   assign le_q_o       = le_q;
   assign inv_q_o      = inv_q;
   assign align_q_o    = aln_q;

endmodule

// File: rtl/lmw_seq.sv
module lmw_seq
   import lmw_seq_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32,
   parameter int NREGS  = 32,
   parameter int DISP_W = 16,
   parameter int IDX_W  = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  first_reg_i,
   input  logic [IDX_W-1:0]  base_idx_i,
   input  logic [XLEN-1:0]   base_val_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic              le_mode_i,
   output logic              mem_req_o,
   output logic [XLEN-1:0]   mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_waddr_o,
   output logic [XLEN-1:0]   rf_wdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              invalid_o,
   output logic              align_err_o
);

   localparam int STEP = WORD_W / 8;

   generate
      if (NREGS != (1 << IDX_W)) begin : g_bad_nregs
         $error("lmw_seq: NREGS must be a power of two matching IDX_W");
      end
      if (XLEN < WORD_W) begin : g_bad_xlen
         $error("lmw_seq: XLEN must be at least WORD_W");
      end
      if (DISP_W > XLEN) begin : g_bad_disp
         $error("lmw_seq: DISP_W must not exceed XLEN");
      end
      if ((WORD_W % 8) != 0) begin : g_bad_word
         $error("lmw_seq: WORD_W must be a whole number of bytes");
      end
   endgenerate

   seq_state_e       state;
   logic             accept;
   logic             step;
   logic [IDX_W-1:0] cur_reg;
   logic [IDX_W-1:0] first_q;
   logic [IDX_W-1:0] base_idx_q;
   logic             le_q;
   logic             inv_q;
   logic             aln_q;
   logic             range_hit;
   logic             align_fault;

   lmw_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .first_reg_i   (first_reg_i),
      .base_idx_i    (base_idx_i),
      .le_mode_i     (le_mode_i),
      .range_hit_i   (range_hit),
      .align_fault_i (align_fault),
      .mem_ack_i     (mem_ack_i),
      .accept_o      (accept),
      .step_o        (step),
      .state_o       (state),
      .cur_reg_o     (cur_reg),
      .first_q_o     (first_q),
      .base_idx_q_o  (base_idx_q),
      .le_q_o        (le_q),
      .inv_q_o       (inv_q),
      .align_q_o     (aln_q)
   );

   lmw_seq_form_check #(.IDX_W(IDX_W)) u_form (
      .first_q_i     (first_q),
      .base_idx_q_i  (base_idx_q),
      .le_q_i        (le_q),
      .range_hit_o   (range_hit),
      .align_fault_o (align_fault)
   );

   lmw_seq_addr_gen #(.XLEN(XLEN), .DISP_W(DISP_W), .STEP(STEP)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (accept),
      .step_i      (step),
      .base_zero_i (base_idx_i == '0),
      .base_val_i  (base_val_i),
      .disp_i      (disp_i),
      .addr_o      (mem_addr_o)
   );

   generate
      if (XLEN > WORD_W) begin : g_wdata_pad
         assign rf_wdata_o = {{(XLEN-WORD_W){1'b0}}, mem_rdata_i};
      end else begin : g_wdata_full
         assign rf_wdata_o = mem_rdata_i;
      end
   endgenerate

   assign mem_req_o   = (state == ST_REQ);
   assign rf_we_o     = (state == ST_WAIT) && mem_ack_i;
   assign rf_waddr_o  = cur_reg;
   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_DONE);
   assign invalid_o   = done_o && inv_q;
   assign align_err_o = done_o && aln_q;

endmodule

// File: rtl/lmw_seq_chk.sv
module lmw_seq_chk #(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              mem_req_o,
   input logic [XLEN-1:0]   mem_addr_o,
   input logic [WORD_W-1:0] mem_rdata_i,
   input logic              rf_we_o,
   input logic [IDX_W-1:0]  rf_waddr_o,
   input logic [XLEN-1:0]   rf_wdata_o,
   input logic              done_o,
   input logic              invalid_o,
   input logic              align_err_o
);

   localparam logic [XLEN-1:0]  STEP_V   = XLEN'(WORD_W / 8);
   localparam logic [IDX_W-1:0] LAST_REG = '1;

   logic [XLEN-1:0]  prev_addr;
   logic             have_addr;
   logic [IDX_W-1:0] prev_reg;
   logic             have_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_addr <= '0;
         have_addr <= 1'b0;
         prev_reg  <= '0;
         have_reg  <= 1'b0;
      end else begin
         if (!busy_o && start_i) begin
            have_addr <= 1'b0;
            have_reg  <= 1'b0;
         end
         if (mem_req_o) begin
            prev_addr <= mem_addr_o;
            have_addr <= 1'b1;
         end
         if (rf_we_o) begin
            prev_reg <= rf_waddr_o;
            have_reg <= 1'b1;
         end
      end
   end

   assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   assert_invalid_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_o |-> done_o);

   assert_align_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      align_err_o |-> done_o);

   assert_fault_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (invalid_o || align_err_o) |-> (!have_reg && !have_addr));

   assert_wdata_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> ((rf_wdata_o[WORD_W-1:0] == mem_rdata_i)
                   && ((rf_wdata_o >> WORD_W) == '0)));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && have_addr) |-> (mem_addr_o == prev_addr + STEP_V));

   assert_reg_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we_o && have_reg) |-> (rf_waddr_o == prev_reg + 1'b1));

   assert_ends_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !invalid_o && !align_err_o) |-> (have_reg && prev_reg == LAST_REG));

endmodule

bind lmw_seq lmw_seq_chk #(
   .XLEN   (XLEN),
   .WORD_W (WORD_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .mem_req_o   (mem_req_o),
   .mem_addr_o  (mem_addr_o),
   .mem_rdata_i (mem_rdata_i),
   .rf_we_o     (rf_we_o),
   .rf_waddr_o  (rf_waddr_o),
   .rf_wdata_o  (rf_wdata_o),
   .done_o      (done_o),
   .invalid_o   (invalid_o),
   .align_err_o (align_err_o)
);

// File: tb/lmw_seq_tb.sv
`timescale 1ns/1ps
module lmw_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [4:0]  first_reg_i = '0;
   logic [4:0]  base_idx_i = '0;
   logic [63:0] base_val_i = '0;
   logic [15:0] disp_i = '0;
   logic        le_mode_i = 1'b0;
   logic        mem_req_o;
   logic [63:0] mem_addr_o;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic        rf_we_o;
   logic [4:0]  rf_waddr_o;
   logic [63:0] rf_wdata_o;
   logic        busy_o;
   logic        done_o;
   logic        invalid_o;
   logic        align_err_o;

   always #10 clk = ~clk;

   lmw_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_reg_i(first_reg_i),
      .base_idx_i(base_idx_i), .base_val_i(base_val_i), .disp_i(disp_i),
      .le_mode_i(le_mode_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .rf_we_o(rf_we_o),
      .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .busy_o(busy_o),
      .done_o(done_o), .invalid_o(invalid_o), .align_err_o(align_err_o)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int lat = 1;

   logic [63:0] req_log [64];
   logic [4:0]  wreg_log [64];
   logic [63:0] wdat_log [64];
   int req_n, wr_n, done_n;
   logic inv_s, aln_s;

   function automatic logic [31:0] mem_word(input logic [63:0] a);
      return a[31:0] ^ a[63:32] ^ 32'h5A3C_96E1;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory responder: inputs driven 2 ns after a rising edge
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_o) begin
            logic [63:0] a;
            a = mem_addr_o;
            repeat (lat) @(posedge clk);
            #2;
            mem_ack_i = 1'b1;
            mem_rdata_i = mem_word(a);
            @(posedge clk);
            #2;
            mem_ack_i = 1'b0;
            mem_rdata_i = '0;
         end
      end
   end

   // monitor: samples on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_o && req_n < 64) begin req_log[req_n] = mem_addr_o; req_n++; end
         if (rf_we_o && wr_n < 64) begin
            wreg_log[wr_n] = rf_waddr_o; wdat_log[wr_n] = rf_wdata_o; wr_n++;
         end
         if (done_o) begin done_n++; inv_s = invalid_o; aln_s = align_err_o; end
      end
   end

   task automatic run_op(input int f, input int bidx, input logic [63:0] bval,
                         input logic [15:0] d, input bit le, input int l,
                         input bit stray);
      int n;
      bit inv;
      logic [63:0] ea;
      bit ok;
      lat = l;
      req_n = 0; wr_n = 0; done_n = 0; inv_s = 0; aln_s = 0;
      @(posedge clk); #2;
      first_reg_i = 5'(f); base_idx_i = 5'(bidx); base_val_i = bval;
      disp_i = d; le_mode_i = le; start_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
      // scramble inputs after acceptance; they must not matter
      base_val_i = ~bval; disp_i = ~d; first_reg_i = 5'd3; base_idx_i = 5'd30;
      if (stray) begin
         repeat (3) @(posedge clk);
         #2; start_i = 1'b1; first_reg_i = 5'd2; le_mode_i = 1'b0;
         @(posedge clk); #2; start_i = 1'b0;
      end
      while (done_n == 0) @(negedge clk);
      @(negedge clk);
      check(!busy_o && !done_o, "R9 idle after single done pulse",
            {62'd0, busy_o, done_o}, 64'd0);
      repeat (4) @(negedge clk);
      check(done_n == 1, "R9/R10 exactly one done", 64'(done_n), 64'd1);

      inv = (bidx >= f);
      n = (inv || le) ? 0 : 32 - f;
      ea = ((bidx == 0) ? 64'd0 : bval) + {{48{d[15]}}, d};
      check(inv_s == inv, "R7 invalid flag", 64'(inv_s), 64'(inv));
      check(aln_s == le, "R8 alignment flag", 64'(aln_s), 64'(le));
      check(req_n == n, "R3/R7/R8 read count", 64'(req_n), 64'(n));
      check(wr_n == n, "R3/R7/R8 write count", 64'(wr_n), 64'(n));
      if (n > 0 && req_n == n && wr_n == n) begin
         ok = (req_log[0] == ea);
         check(ok, "R2 first address", req_log[0], ea);
         ok = 1;
         for (int k = 0; k < n; k++) begin
            logic [63:0] ak;
            ak = ea + 64'(4 * k);
            if (req_log[k] != ak || wreg_log[k] != 5'(f + k)
                || wdat_log[k] != {32'd0, mem_word(ak)}) begin
               ok = 0;
               check(0, "R3/R4/R5 word sequence", wdat_log[k], {32'd0, mem_word(ak)});
            end
         end
         if (ok) check(1, "R3/R4/R5 word sequence", 0, 0);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy_o && !mem_req_o && !rf_we_o && !done_o && !invalid_o && !align_err_o,
            "R1 reset state",
            {58'd0, busy_o, mem_req_o, rf_we_o, done_o, invalid_o, align_err_o}, 64'd0);

      // R3 R4 R5: every starting register with a valid base
      for (int f = 1; f < 32; f++)
         run_op(f, (f == 1) ? 0 : f - 1, 64'h0000_1234_5678_0000 + 64'(f * 256),
                16'(f * 12), 1'b0, 1 + (f % 3), 1'b0);
      // R2: zero base field with negative displacement
      run_op(9, 0, 64'hDEAD_BEEF_0000_0000, 16'hFF00, 1'b0, 1, 1'b0);
      // R4: address wrap past the top of the space
      run_op(27, 26, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0004, 1'b0, 2, 1'b0);
      // R7: base field in range, across starting registers
      for (int f = 0; f < 32; f += 3)
         run_op(f, f + ((f * 7) % (32 - f)), 64'h100, 16'h10, 1'b0, 1, 1'b0);
      run_op(0, 0, 64'h0, 16'h0, 1'b0, 1, 1'b0);
      run_op(31, 31, 64'h40, 16'h0, 1'b0, 1, 1'b0);
      // R8: little-endian mode, alone and with an invalid form
      run_op(20, 4, 64'h2000, 16'h8, 1'b1, 1, 1'b0);
      run_op(10, 15, 64'h2000, 16'h8, 1'b1, 1, 1'b0);
      // R10: stray start while busy
      run_op(20, 7, 64'h0000_0000_0001_0000, 16'h0020, 1'b0, 2, 1'b1);
      run_op(30, 0, 64'h0, 16'h7FFC, 1'b0, 3, 1'b1);

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule